// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block keeps a small ring of in-flight stores and answers byte-level forwarding lookups for a three-step load pipeline. Each store slot holds a virtual line address, a physical line address, a byte-enable mask for one 16-byte line, store data, and two readiness flags: one for the address and one for the data. Stores are allocated at the tail, given their address and data later in any order, and retired from the head.

A load first presents its store-ring pointer (step 0). The block turns that pointer into a registered per-slot "older than this load" mask, so the lookup step never has to compare pointers. In step 1 the load presents its addresses and byte mask, and the block returns a fast byte-forward mask and a fast data-not-ready flag in the same cycle. One cycle later, in step 2, it returns the forwarded bytes, the final byte mask, a data-not-ready flag and an address-not-ready flag, each with the pointer of the store that caused it, and a flag that is set when virtual and physical matching disagree.

Top module: `stfwd_unit`

## Requirements
- R1: After reset the ring is empty, `enq_ptr_o` is 0, `ld2_valid_o` is 0, and a lookup finds nothing.
- R2: Ring pointers are {wrap bit, slot index}. Each accepted `enq_i` advances `enq_ptr_o` by one, modulo 2*DEPTH. `enq_i` is ignored when all DEPTH slots are live. `deq_i` retires the oldest live slot and is ignored when the ring is empty.
- R3: A slot's address and byte mask are visible to lookups from the second rising clock edge after the `aw_valid_i` request. Before that edge the slot counts as address-unknown.
- R4: Byte b is forwarded when an older live store has a known address, the same virtual line (address bits above bit 3), store mask bit b and load mask bit b set, and valid data. Its value is byte b of that store's data. Bytes that are not forwarded read 0. Step-2 results appear one clock after the step-1 inputs, with `ld2_valid_o` marking them.
- R5: When several older stores can supply a byte, the one nearest the load (the youngest older store) supplies it, including across index wraparound.
- R6: Stores at or after the load's pointer and retired stores never forward and never raise a flag.
- R7: If the store selected for a byte has no data yet, the byte is not forwarded and `data_inv_o` (and `fast_data_inv_o` in step 1) is set. `data_inv_ptr_o` gives the nearest such store and is 0 when the flag is clear.
- R8: If any older live store has an unknown address, `addr_inv_o` is set and `addr_inv_ptr_o` gives the nearest such store. The pointer is 0 when the flag is clear.
- R9: `match_inv_o` is set when the set of older, address-known stores matching the load by virtual line with overlapping bytes differs from the set matching by physical line (address bits above bit 3).
- R10: `fast_fwd_mask_o` is valid combinationally during step 1 and equals the `fwd_mask_o` returned in step 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enq_i | input | 1 | Allocate a store slot at the tail |
| enq_ptr_o | output | 4 | Tail pointer {wrap, index} |
| deq_i | input | 1 | Retire the head slot |
| aw_valid_i | input | 1 | Address write request |
| aw_idx_i | input | 3 | Slot index for the address write |
| aw_vaddr_i | input | 32 | Store virtual address |
| aw_paddr_i | input | 32 | Store physical address |
| aw_mask_i | input | 16 | Store byte mask |
| dw_valid_i | input | 1 | Data write request |
| dw_idx_i | input | 3 | Slot index for the data write |
| dw_data_i | input | 128 | Store data, byte b in bits 8b+7:8b |
| ld0_valid_i | input | 1 | Step-0 load valid |
| ld0_sq_ptr_i | input | 4 | Load's ring pointer (first store younger than the load) |
| ld1_valid_i | input | 1 | Step-1 load valid |
| ld1_vaddr_i | input | 32 | Load virtual address |
| ld1_paddr_i | input | 32 | Load physical address |
| ld1_mask_i | input | 16 | Load byte mask |
| fast_fwd_mask_o | output | 16 | Step-1 forwardable bytes |
| fast_data_inv_o | output | 1 | Step-1 data-not-ready flag |
| ld2_valid_o | output | 1 | Step-2 results valid |
| fwd_mask_o | output | 16 | Forwarded bytes |
| fwd_data_o | output | 128 | Forwarded data |
| data_inv_o | output | 1 | Matching store data not ready |
| data_inv_ptr_o | output | 4 | Pointer of that store |
| addr_inv_o | output | 1 | Older store address unknown |
| addr_inv_ptr_o | output | 4 | Pointer of that store |
| match_inv_o | output | 1 | Virtual and physical match sets disagree |

## Verification
The hardest case to reach from the ports is youngest-older selection after the ring indices have wrapped. The nearest older store then sits at a lower index than an older one, and the load's wrap bit differs from the head's. The stimulus retires five stores, fills the ring until it is full, and queries from a load pointer whose index lies below the surviving head. A second hard case is the two-edge address latency. The stimulus fixes a load's age mask, holds its step-1 inputs, and watches the fast mask on each side of the second edge after the address write.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;
  localparam int SQ_DEPTH_DEF   = 8;
  localparam int VA_W_DEF       = 32;
  localparam int PA_W_DEF       = 32;
  localparam int LINE_BYTES_DEF = 16;

  // slot j lies in [head, ld) on a ring, given whether both pointers share a wrap bit
  function automatic logic in_window(int j, int head, int ld, logic same_wrap);
    if (same_wrap) return (j >= head) && (j < ld);
    return (j >= head) || (j < ld);
  endfunction
endpackage

// File: rtl/stfwd_queue.sv
module stfwd_queue #(
  parameter int DEPTH = 8,
  parameter int VL_W  = 28,
  parameter int PL_W  = 28,
  parameter int NB    = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int DATA_W = 8 * NB
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enq_i,
  input  logic                          deq_i,
  input  logic                          aw_valid_i,
  input  logic [IDX_W-1:0]              aw_idx_i,
  input  logic [VL_W-1:0]               aw_vline_i,
  input  logic [PL_W-1:0]               aw_pline_i,
  input  logic [NB-1:0]                 aw_mask_i,
  input  logic                          dw_valid_i,
  input  logic [IDX_W-1:0]              dw_idx_i,
  input  logic [DATA_W-1:0]             dw_data_i,
  output logic [PTR_W-1:0]              head_ptr_o,
  output logic [PTR_W-1:0]              tail_ptr_o,
  output logic [DEPTH-1:0]              valid_o,
  output logic [DEPTH-1:0]              addr_ok_o,
  output logic [DEPTH-1:0]              data_ok_o,
  output logic [DEPTH-1:0][VL_W-1:0]    vline_o,
  output logic [DEPTH-1:0][PL_W-1:0]    pline_o,
  output logic [DEPTH-1:0][NB-1:0]      mask_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  data_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [DEPTH-1:0] valid_q, aok_q, dok_q;
  logic [DEPTH-1:0][VL_W-1:0]   vl_q;
  logic [DEPTH-1:0][PL_W-1:0]   pl_q;
  logic [DEPTH-1:0][NB-1:0]     mk_q;
  logic [DEPTH-1:0][DATA_W-1:0] dt_q;

  // one stage between address request and slot update
  logic             aw_s_valid;
  logic [IDX_W-1:0] aw_s_idx;
  logic [VL_W-1:0]  aw_s_vl;
  logic [PL_W-1:0]  aw_s_pl;
  logic [NB-1:0]    aw_s_mk;

  logic full, empty;
  assign empty = head_q == tail_q;
  assign full  = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      tail_q     <= '0;
      valid_q    <= '0;
      aok_q      <= '0;
      dok_q      <= '0;
      vl_q       <= '0;
      pl_q       <= '0;
      mk_q       <= '0;
      dt_q       <= '0;
      aw_s_valid <= 1'b0;
      aw_s_idx   <= '0;
      aw_s_vl    <= '0;
      aw_s_pl    <= '0;
      aw_s_mk    <= '0;
    end else begin
      if (deq_i && !empty) begin
        valid_q[head_q[IDX_W-1:0]] <= 1'b0;
        head_q <= head_q + 1'b1;
      end
      if (enq_i && !full) begin
        valid_q[tail_q[IDX_W-1:0]] <= 1'b1;
        aok_q[tail_q[IDX_W-1:0]]   <= 1'b0;
        dok_q[tail_q[IDX_W-1:0]]   <= 1'b0;
        tail_q <= tail_q + 1'b1;
      end
      aw_s_valid <= aw_valid_i;
      aw_s_idx   <= aw_idx_i;
      aw_s_vl    <= aw_vline_i;
      aw_s_pl    <= aw_pline_i;
      aw_s_mk    <= aw_mask_i;
      if (aw_s_valid) begin
        aok_q[aw_s_idx] <= 1'b1;
        vl_q[aw_s_idx]  <= aw_s_vl;
        pl_q[aw_s_idx]  <= aw_s_pl;
        mk_q[aw_s_idx]  <= aw_s_mk;
      end
      if (dw_valid_i) begin
        dok_q[dw_idx_i] <= 1'b1;
        dt_q[dw_idx_i]  <= dw_data_i;
      end
    end
  end

  assign head_ptr_o = head_q;
  assign tail_ptr_o = tail_q;
  assign valid_o    = valid_q;
  assign addr_ok_o  = aok_q;
  assign data_ok_o  = dok_q;
  assign vline_o    = vl_q;
  assign pline_o    = pl_q;
  assign mask_o     = mk_q;
  assign data_o     = dt_q;

  p_enq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && !full) |=> (tail_ptr_o == $past(tail_ptr_o) + 1'b1));
  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && full) |=> $stable(tail_ptr_o));
  p_aw_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_s_valid |=> addr_ok_o[$past(aw_s_idx)]);
endmodule

// File: rtl/stfwd_age.sv
module stfwd_age import stfwd_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld0_valid_i,
  input  logic [PTR_W-1:0] ld0_ptr_i,
  input  logic [PTR_W-1:0] head_ptr_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] age_o,
  output logic [PTR_W-1:0] ld_ptr_o
);
  logic [DEPTH-1:0] older;
  logic             same_wrap;

  assign same_wrap = ld0_ptr_i[IDX_W] == head_ptr_i[IDX_W];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    assign older[j] = valid_i[j] &
      in_window(j, int'(head_ptr_i[IDX_W-1:0]), int'(ld0_ptr_i[IDX_W-1:0]), same_wrap);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_o    <= '0;
      ld_ptr_o <= '0;
    end else if (ld0_valid_i) begin
      age_o    <= older;
      ld_ptr_o <= ld0_ptr_i;
    end
  end

  p_age_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld0_valid_i |=> ($stable(age_o) && $stable(ld_ptr_o)));
endmodule

// File: rtl/stfwd_lookup.sv
module stfwd_lookup #(
  parameter int DEPTH = 8,
  parameter int VL_W  = 28,
  parameter int PL_W  = 28,
  parameter int NB    = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int DATA_W = 8 * NB
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DEPTH-1:0]              age_i,
  input  logic [PTR_W-1:0]              ld_ptr_i,
  input  logic [DEPTH-1:0]              valid_i,
  input  logic [DEPTH-1:0]              addr_ok_i,
  input  logic [DEPTH-1:0]              data_ok_i,
  input  logic [DEPTH-1:0][VL_W-1:0]    vline_i,
  input  logic [DEPTH-1:0][PL_W-1:0]    pline_i,
  input  logic [DEPTH-1:0][NB-1:0]      mask_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  data_i,
  input  logic                          ld1_valid_i,
  input  logic [VL_W-1:0]               ld1_vline_i,
  input  logic [PL_W-1:0]               ld1_pline_i,
  input  logic [NB-1:0]                 ld1_mask_i,
  output logic [NB-1:0]                 fast_fwd_mask_o,
  output logic                          fast_data_inv_o,
  output logic                          ld2_valid_o,
  output logic [NB-1:0]                 fwd_mask_o,
  output logic [DATA_W-1:0]             fwd_data_o,
  output logic                          data_inv_o,
  output logic [PTR_W-1:0]              data_inv_ptr_o,
  output logic                          addr_inv_o,
  output logic [PTR_W-1:0]              addr_inv_ptr_o,
  output logic                          match_inv_o
);
  logic [IDX_W-1:0]  ld_idx;
  logic              ld_wrap;
  logic [DEPTH-1:0]  older, vhit, phit, unknown, blocked;
  logic [NB-1:0]     fmask;
  logic [DATA_W-1:0] fdata;
  logic              d_found, a_found;
  logic [IDX_W-1:0]  d_idx, a_idx;
  logic [PTR_W-1:0]  d_ptr, a_ptr;

  assign ld_idx  = ld_ptr_i[IDX_W-1:0];
  assign ld_wrap = ld_ptr_i[IDX_W];

  for (genvar j = 0; j < DEPTH; j++) begin : g_match
    assign older[j]   = age_i[j] & valid_i[j];
    assign unknown[j] = older[j] & ~addr_ok_i[j];
    assign vhit[j]    = older[j] & addr_ok_i[j] & (vline_i[j] == ld1_vline_i) & (|(mask_i[j] & ld1_mask_i));
    assign phit[j]    = older[j] & addr_ok_i[j] & (pline_i[j] == ld1_pline_i) & (|(mask_i[j] & ld1_mask_i));
  end

  // per byte: nearest older candidate, scanning down from the load
  always_comb begin
    logic             found;
    logic [IDX_W-1:0] sel, j;
    fmask   = '0;
    fdata   = '0;
    blocked = '0;
    for (int b = 0; b < NB; b++) begin
      found = 1'b0;
      sel   = '0;
      for (int k = 0; k < DEPTH; k++) begin
        j = ld_idx - IDX_W'(k + 1);
        if (!found && vhit[j] && mask_i[j][b] && ld1_mask_i[b]) begin
          found = 1'b1;
          sel   = j;
        end
      end
      if (found && data_ok_i[sel]) begin
        fmask[b]        = 1'b1;
        fdata[8*b +: 8] = data_i[sel][8*b +: 8];
      end else if (found) begin
        blocked[sel] = 1'b1;
      end
    end
  end

  always_comb begin
    logic [IDX_W-1:0] j;
    d_found = 1'b0;
    a_found = 1'b0;
    d_idx   = '0;
    a_idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = ld_idx - IDX_W'(k + 1);
      if (!d_found && blocked[j]) begin
        d_found = 1'b1;
        d_idx   = j;
      end
      if (!a_found && unknown[j]) begin
        a_found = 1'b1;
        a_idx   = j;
      end
    end
  end

  // a slot below the load index shares its wrap bit, otherwise it is one lap behind
  assign d_ptr = d_found ? {(d_idx < ld_idx) ? ld_wrap : ~ld_wrap, d_idx} : '0;
  assign a_ptr = a_found ? {(a_idx < ld_idx) ? ld_wrap : ~ld_wrap, a_idx} : '0;

  assign fast_fwd_mask_o = fmask;
  assign fast_data_inv_o = d_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld2_valid_o    <= 1'b0;
      fwd_mask_o     <= '0;
      fwd_data_o     <= '0;
      data_inv_o     <= 1'b0;
      data_inv_ptr_o <= '0;
      addr_inv_o     <= 1'b0;
      addr_inv_ptr_o <= '0;
      match_inv_o    <= 1'b0;
    end else begin
      ld2_valid_o <= ld1_valid_i;
      if (ld1_valid_i) begin
        fwd_mask_o     <= fmask;
        fwd_data_o     <= fdata;
        data_inv_o     <= d_found;
        data_inv_ptr_o <= d_ptr;
        addr_inv_o     <= a_found;
        addr_inv_ptr_o <= a_ptr;
        match_inv_o    <= vhit != phit;
      end else begin
        fwd_mask_o     <= '0;
        fwd_data_o     <= '0;
        data_inv_o     <= 1'b0;
        data_inv_ptr_o <= '0;
        addr_inv_o     <= 1'b0;
        addr_inv_ptr_o <= '0;
        match_inv_o    <= 1'b0;
      end
    end
  end

  p_s2_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1_valid_i |=> ld2_valid_o);
  p_s2_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld1_valid_i |=> (!ld2_valid_o && fwd_mask_o == '0));
  p_fast_in_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_fwd_mask_o & ~ld1_mask_i) == '0);
  p_mask_agrees_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1_valid_i |=> fwd_mask_o == $past(fast_fwd_mask_o));
  p_dptr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_inv_o |-> data_inv_ptr_o == '0);
  p_aptr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_inv_o |-> addr_inv_ptr_o == '0);
endmodule

// File: rtl/stfwd_unit.sv
module stfwd_unit import stfwd_pkg::*; #(
  parameter int DEPTH      = SQ_DEPTH_DEF,
  parameter int VA_W       = VA_W_DEF,
  parameter int PA_W       = PA_W_DEF,
  parameter int LINE_BYTES = LINE_BYTES_DEF,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int DATA_W = 8 * LINE_BYTES,
  localparam int VL_W   = VA_W - OFF_W,
  localparam int PL_W   = PA_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enq_i,
  output logic [PTR_W-1:0]      enq_ptr_o,
  input  logic                  deq_i,
  input  logic                  aw_valid_i,
  input  logic [IDX_W-1:0]      aw_idx_i,
  input  logic [VA_W-1:0]       aw_vaddr_i,
  input  logic [PA_W-1:0]       aw_paddr_i,
  input  logic [LINE_BYTES-1:0] aw_mask_i,
  input  logic                  dw_valid_i,
  input  logic [IDX_W-1:0]      dw_idx_i,
  input  logic [DATA_W-1:0]     dw_data_i,
  input  logic                  ld0_valid_i,
  input  logic [PTR_W-1:0]      ld0_sq_ptr_i,
  input  logic                  ld1_valid_i,
  input  logic [VA_W-1:0]       ld1_vaddr_i,
  input  logic [PA_W-1:0]       ld1_paddr_i,
  input  logic [LINE_BYTES-1:0] ld1_mask_i,
  output logic [LINE_BYTES-1:0] fast_fwd_mask_o,
  output logic                  fast_data_inv_o,
  output logic                  ld2_valid_o,
  output logic [LINE_BYTES-1:0] fwd_mask_o,
  output logic [DATA_W-1:0]     fwd_data_o,
  output logic                  data_inv_o,
  output logic [PTR_W-1:0]      data_inv_ptr_o,
  output logic                  addr_inv_o,
  output logic [PTR_W-1:0]      addr_inv_ptr_o,
  output logic                  match_inv_o
);
  logic [PTR_W-1:0]                 head_ptr, ld_ptr;
  logic [DEPTH-1:0]                 valid, addr_ok, data_ok, age;
  logic [DEPTH-1:0][VL_W-1:0]       vline;
  logic [DEPTH-1:0][PL_W-1:0]       pline;
  logic [DEPTH-1:0][LINE_BYTES-1:0] smask;
  logic [DEPTH-1:0][DATA_W-1:0]     sdata;

  // byte offsets are carried by the masks, not compared
  logic unused_offsets;
  assign unused_offsets = ^{aw_vaddr_i[OFF_W-1:0], aw_paddr_i[OFF_W-1:0],
                            ld1_vaddr_i[OFF_W-1:0], ld1_paddr_i[OFF_W-1:0]};

  stfwd_queue #(.DEPTH(DEPTH), .VL_W(VL_W), .PL_W(PL_W), .NB(LINE_BYTES)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enq_i      (enq_i),
    .deq_i      (deq_i),
    .aw_valid_i (aw_valid_i),
    .aw_idx_i   (aw_idx_i),
    .aw_vline_i (aw_vaddr_i[VA_W-1:OFF_W]),
    .aw_pline_i (aw_paddr_i[PA_W-1:OFF_W]),
    .aw_mask_i  (aw_mask_i),
    .dw_valid_i (dw_valid_i),
    .dw_idx_i   (dw_idx_i),
    .dw_data_i  (dw_data_i),
    .head_ptr_o (head_ptr),
    .tail_ptr_o (enq_ptr_o),
    .valid_o    (valid),
    .addr_ok_o  (addr_ok),
    .data_ok_o  (data_ok),
    .vline_o    (vline),
    .pline_o    (pline),
    .mask_o     (smask),
    .data_o     (sdata)
  );

  stfwd_age #(.DEPTH(DEPTH)) u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld0_valid_i (ld0_valid_i),
    .ld0_ptr_i   (ld0_sq_ptr_i),
    .head_ptr_i  (head_ptr),
    .valid_i     (valid),
    .age_o       (age),
    .ld_ptr_o    (ld_ptr)
  );

  stfwd_lookup #(.DEPTH(DEPTH), .VL_W(VL_W), .PL_W(PL_W), .NB(LINE_BYTES)) u_lookup (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .age_i           (age),
    .ld_ptr_i        (ld_ptr),
    .valid_i         (valid),
    .addr_ok_i       (addr_ok),
    .data_ok_i       (data_ok),
    .vline_i         (vline),
    .pline_i         (pline),
    .mask_i          (smask),
    .data_i          (sdata),
    .ld1_valid_i     (ld1_valid_i),
    .ld1_vline_i     (ld1_vaddr_i[VA_W-1:OFF_W]),
    .ld1_pline_i     (ld1_paddr_i[PA_W-1:OFF_W]),
    .ld1_mask_i      (ld1_mask_i),
    .fast_fwd_mask_o (fast_fwd_mask_o),
    .fast_data_inv_o (fast_data_inv_o),
    .ld2_valid_o     (ld2_valid_o),
    .fwd_mask_o      (fwd_mask_o),
    .fwd_data_o      (fwd_data_o),
    .data_inv_o      (data_inv_o),
    .data_inv_ptr_o  (data_inv_ptr_o),
    .addr_inv_o      (addr_inv_o),
    .addr_inv_ptr_o  (addr_inv_ptr_o),
    .match_inv_o     (match_inv_o)
  );
endmodule

// File: tb/stfwd_unit_tb.sv
module stfwd_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         enq, deq, aw_v, dw_v, ld0_v, ld1_v;
  logic [3:0]   enq_ptr, ld0_ptr;
  logic [2:0]   aw_idx, dw_idx;
  logic [31:0]  aw_va, aw_pa, ld_va, ld_pa;
  logic [15:0]  aw_mk, ld_mk;
  logic [127:0] dw_dt;
  logic [15:0]  ffm, fm;
  logic         fdi, l2v, di, ai, mi;
  logic [127:0] fd;
  logic [3:0]   dptr, aptr;

  stfwd_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enq_i(enq), .enq_ptr_o(enq_ptr), .deq_i(deq),
    .aw_valid_i(aw_v), .aw_idx_i(aw_idx), .aw_vaddr_i(aw_va), .aw_paddr_i(aw_pa), .aw_mask_i(aw_mk),
    .dw_valid_i(dw_v), .dw_idx_i(dw_idx), .dw_data_i(dw_dt),
    .ld0_valid_i(ld0_v), .ld0_sq_ptr_i(ld0_ptr),
    .ld1_valid_i(ld1_v), .ld1_vaddr_i(ld_va), .ld1_paddr_i(ld_pa), .ld1_mask_i(ld_mk),
    .fast_fwd_mask_o(ffm), .fast_data_inv_o(fdi), .ld2_valid_o(l2v),
    .fwd_mask_o(fm), .fwd_data_o(fd), .data_inv_o(di), .data_inv_ptr_o(dptr),
    .addr_inv_o(ai), .addr_inv_ptr_o(aptr), .match_inv_o(mi)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, ordered by store sequence number
  logic         m_av [64];
  logic         m_dv [64];
  logic [31:0]  m_va [64];
  logic [31:0]  m_pa [64];
  logic [15:0]  m_mk [64];
  logic [127:0] m_dt [64];
  int head_seq = 0, tail_seq = 0;

  typedef struct {
    string        tag;
    logic [15:0]  mask;
    logic [127:0] data;
    logic         dinv;
    logic [3:0]   dptr;
    logic         ainv;
    logic [3:0]   aptr;
    logic         minv;
  } exp_t;
  exp_t sb[$];

  function automatic exp_t model(string tag, int ls, logic [31:0] va, logic [31:0] pa, logic [15:0] m);
    exp_t e;
    int dbest = -1, abest = -1;
    e.tag = tag; e.mask = '0; e.data = '0; e.minv = 1'b0;
    for (int s = head_seq; s < ls; s++) begin
      if (!m_av[s]) abest = s;
      else if (((m_va[s][31:4] == va[31:4]) && ((m_mk[s] & m) != 0)) !=
               ((m_pa[s][31:4] == pa[31:4]) && ((m_mk[s] & m) != 0))) e.minv = 1'b1;
    end
    for (int b = 0; b < 16; b++) begin
      int best = -1;
      for (int s = head_seq; s < ls; s++)
        if (m_av[s] && m_va[s][31:4] == va[31:4] && m_mk[s][b] && m[b]) best = s;
      if (best >= 0) begin
        if (m_dv[best]) begin
          e.mask[b] = 1'b1;
          e.data[8*b +: 8] = m_dt[best][8*b +: 8];
        end else if (best > dbest) dbest = best;
      end
    end
    e.dinv = dbest >= 0;
    e.dptr = e.dinv ? 4'(dbest % 16) : 4'd0;
    e.ainv = abest >= 0;
    e.aptr = e.ainv ? 4'(abest % 16) : 4'd0;
    return e;
  endfunction

  function automatic logic [127:0] pattern(int s);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[8*b +: 8] = 8'(s * 16 + b) ^ 8'hA5;
    return d;
  endfunction

  task automatic do_enq();
    @(negedge clk); enq = 1'b1;
    @(negedge clk); enq = 1'b0;
    if (tail_seq - head_seq < 8) begin
      m_av[tail_seq] = 1'b0; m_dv[tail_seq] = 1'b0; tail_seq++;
    end
  endtask

  task automatic do_deq();
    @(negedge clk); deq = 1'b1;
    @(negedge clk); deq = 1'b0;
    if (tail_seq > head_seq) head_seq++;
  endtask

  task automatic do_aw(int s, logic [31:0] va, logic [31:0] pa, logic [15:0] m);
    @(negedge clk); aw_v = 1'b1; aw_idx = 3'(s % 8); aw_va = va; aw_pa = pa; aw_mk = m;
    @(negedge clk); aw_v = 1'b0;
    @(negedge clk);
    m_av[s] = 1'b1; m_va[s] = va; m_pa[s] = pa; m_mk[s] = m;
  endtask

  task automatic do_dw(int s);
    @(negedge clk); dw_v = 1'b1; dw_idx = 3'(s % 8); dw_dt = pattern(s);
    @(negedge clk); dw_v = 1'b0;
    m_dv[s] = 1'b1; m_dt[s] = pattern(s);
  endtask

  // driver: steps 0 and 1, fast checks, push expected step-2 item
  task automatic query(string tag, int ls, logic [31:0] va, logic [31:0] pa, logic [15:0] m);
    exp_t e;
    @(negedge clk); ld0_v = 1'b1; ld0_ptr = 4'(ls % 16);
    @(negedge clk); ld0_v = 1'b0; ld1_v = 1'b1; ld_va = va; ld_pa = pa; ld_mk = m;
    #1;
    e = model(tag, ls, va, pa, m);
    chk({tag, " R10 fast mask"}, 128'(ffm), 128'(e.mask));
    chk({tag, " R7 fast data-inv"}, 128'(fdi), 128'(e.dinv));
    sb.push_back(e);
    @(negedge clk); ld1_v = 1'b0;
  endtask

  // monitor: compare step-2 results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && l2v) begin
      if (sb.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R4 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " R4 mask"}, 128'(fm), 128'(e.mask));
        chk({e.tag, " R4 data"}, fd, e.data);
        chk({e.tag, " R7 data-inv"}, 128'({di, dptr}), 128'({e.dinv, e.dptr}));
        chk({e.tag, " R8 addr-inv"}, 128'({ai, aptr}), 128'({e.ainv, e.aptr}));
        chk({e.tag, " R9 match-inv"}, 128'(mi), 128'(e.minv));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    enq = 0; deq = 0; aw_v = 0; dw_v = 0; ld0_v = 0; ld1_v = 0;
    aw_idx = 0; dw_idx = 0; aw_va = 0; aw_pa = 0; aw_mk = 0; dw_dt = 0;
    ld0_ptr = 0; ld_va = 0; ld_pa = 0; ld_mk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enq ptr", 128'(enq_ptr), 0);
    chk("R1 step2 idle", 128'(l2v), 0);
    query("R1 empty", 0, 32'h1000, 32'h1000, 16'hFFFF);

    for (int i = 0; i < 3; i++) do_enq();
    chk("R2 ptr after 3", 128'(enq_ptr), 3);

    do_aw(0, 32'h1000, 32'h1000, 16'h00FF); do_dw(0);
    query("R4 single", 3, 32'h1004, 32'h1004, 16'h0FF0);
    query("R4 other line", 3, 32'h2000, 32'h2000, 16'hFFFF);

    do_aw(1, 32'h1000, 32'h1000, 16'h00F0); do_dw(1);
    query("R5 youngest", 3, 32'h1000, 32'h1000, 16'h00FF);
    query("R6 younger ignored", 1, 32'h1000, 32'h1000, 16'h00FF);

    do_aw(2, 32'h1000, 32'h1000, 16'h0030);
    query("R7 no data", 3, 32'h1000, 32'h1000, 16'h00FF);

    do_enq();
    query("R8 addr unknown", 4, 32'h1000, 32'h1000, 16'h00FF);

    do_aw(3, 32'h3000, 32'h9000, 16'hFFFF); do_dw(3);
    query("R9 va/pa differ", 4, 32'h3008, 32'h7000, 16'hFF00);
    query("R9 va/pa agree", 4, 32'h3008, 32'h9008, 16'hFF00);

    // R3: fixed age mask, watch the fast mask around the second edge
    do_enq(); do_dw(4);
    @(negedge clk); ld0_v = 1'b1; ld0_ptr = 4'd5;
    @(negedge clk); ld0_v = 1'b0; ld_va = 32'h5000; ld_pa = 32'h5000; ld_mk = 16'hFFFF;
    aw_v = 1'b1; aw_idx = 3'd4; aw_va = 32'h5000; aw_pa = 32'h5000; aw_mk = 16'h000F;
    @(negedge clk); aw_v = 1'b0;
    #1 chk("R3 before second edge", 128'(ffm), 0);
    @(negedge clk);
    #1 chk("R3 after second edge", 128'(ffm), 128'h000F);
    m_av[4] = 1'b1; m_va[4] = 32'h5000; m_pa[4] = 32'h5000; m_mk[4] = 16'h000F;
    query("R3 landed", 5, 32'h5000, 32'h5000, 16'h00FF);

    for (int i = 0; i < 5; i++) do_deq();
    query("R6 retired ignored", 5, 32'h1000, 32'h1000, 16'hFFFF);

    for (int i = 0; i < 8; i++) do_enq();
    chk("R2 ptr wraps", 128'(enq_ptr), 13);
    do_enq();
    chk("R2 enq when full ignored", 128'(enq_ptr), 13);

    do_aw(11, 32'h8000, 32'h8000, 16'h00FF); do_dw(11);
    do_aw(12, 32'h8000, 32'h8000, 16'h000F); do_dw(12);
    query("R5 across wrap", 13, 32'h8000, 32'h8000, 16'h00FF);
    query("R6 across wrap", 12, 32'h8000, 32'h8000, 16'h00FF);

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", 128'(sb.size()), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule